// File: doc/BRIEF.md
# Right-Justified Serial Audio Receiver

This block takes a three-wire stereo audio stream into the system clock domain. The three wires are a bit clock, a channel-select clock and a data line. Each sample is a two's-complement word sent most significant bit first. The data bit is sampled on the rising bit-clock edge. The channel-select level tells which channel a slot carries: high is left, low is right. A change of that level ends the slot.

The word is aligned to the end of the slot. When channel select changes, the block therefore keeps the 18 most recent bits captured in the slot that just ended. It then presents them as a parallel sample with a channel tag and a one-cycle valid strobe. A slot with too few bit clocks is rejected. In that case an error strobe is raised in place of a sample.

All three serial wires first pass through two-flop synchronisers, and edges are found on the system clock. The system clock must run well above the bit clock. The first channel-select change after reset only arms the receiver, because the slot before it began at an unknown point.

Top module: `rj_audio_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `smp_valid` and `frame_err` are 0, and `smp_data` and `smp_left` are 0.
- R2: A delivered `smp_data` equals the last 18 bits captured on rising bit-clock edges before the channel-select change. The bit captured first of those 18 lands in bit 17 (the sign bit) and the last lands in bit 0.
- R3: `smp_left` is 1 when the ended slot had channel select high, and 0 when it had channel select low.
- R4: For each accepted slot, `smp_valid` is high for exactly one cycle. That cycle is the third rising system-clock edge after the channel-select pin changes. Without a channel-select change there is never a strobe.
- R5: A slot that carries more than 18 bit clocks delivers only its last 18 bits. The leading extra bits have no effect on `smp_data`.
- R6: A full period must hold at least 36 bit clocks, so each slot must hold at least 18 rising edges. A shorter slot gives a one-cycle `frame_err` at the time a sample would have appeared. In that case `smp_valid` stays 0 and `smp_data`/`smp_left` keep their previous values.
- R7: The first channel-select change after reset produces neither `smp_valid` nor `frame_err`.
- R8: `smp_data` and `smp_left` change only in a cycle where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| ws_in | input | 1 | Channel-select clock, high = left, asynchronous |
| sd_in | input | 1 | Serial data, MSB first |
| smp_data | output | 18 | Last completed sample, two's complement |
| smp_left | output | 1 | Channel tag of `smp_data`, 1 = left |
| smp_valid | output | 1 | One-cycle strobe for a new sample |
| frame_err | output | 1 | One-cycle strobe for a short slot |

## Verification
Both strobes and the sample registers respond on the third rising system-clock edge after the channel-select pin changes. That delay is two synchroniser stages plus the output register. A captured data bit reaches the shift register on the third edge after its rising bit-clock edge.

The bench changes its pins only on falling system-clock edges, several cycles clear of other events. For each channel-select change it stores the expected result under the cycle number three edges later. On every falling edge it compares all four outputs against that schedule. Where no event is due, it compares against the held values.

// File: rtl/rjrx_pkg.sv
package rjrx_pkg;

    localparam int unsigned RJ_WORD_W      = 18;
    localparam int unsigned RJ_MIN_PERIOD  = 36;
    localparam int unsigned RJ_SYNC_STAGES = 2;

    typedef struct packed {
        logic [RJ_WORD_W-1:0] word;
        logic                 left;
    } rj_sample_t;

    typedef enum logic [1:0] {
        SLOT_NONE   = 2'd0,
        SLOT_PRIME  = 2'd1,
        SLOT_ACCEPT = 2'd2,
        SLOT_SHORT  = 2'd3
    } slot_verdict_e;

    function automatic slot_verdict_e judge_slot(input logic boundary,
                                                 input logic armed,
                                                 input logic full);
        if (!boundary)  return SLOT_NONE;
        if (!armed)     return SLOT_PRIME;
        if (full)       return SLOT_ACCEPT;
        return SLOT_SHORT;
    endfunction

endpackage

// File: rtl/rjrx_sync.sv
module rjrx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= '0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rjrx_edge.sv
module rjrx_edge (
    input  logic clk,
    input  logic rst,
    input  logic bclk_s,
    input  logic ws_s,
    output logic bclk_rise,
    output logic ws_edge,
    output logic ws_level_old
);
    logic bclk_q;
    logic ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
            ws_q   <= 1'b0;
        end else begin
            bclk_q <= bclk_s;
            ws_q   <= ws_s;
        end
    end

    assign bclk_rise    = bclk_s & ~bclk_q;
    assign ws_edge      = ws_s ^ ws_q;
    assign ws_level_old = ws_q;
endmodule

// File: rtl/rjrx_shift.sv
module rjrx_shift #(
    parameter int unsigned WORD_W   = 18,
    parameter int unsigned MIN_SLOT = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_in,
    input  logic              bclk_rise,
    input  logic              ws_edge,
    output logic [WORD_W-1:0] word,
    output logic              slot_full
);
    localparam int unsigned CNT_W = $clog2(MIN_SLOT + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_SLOT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
        end else begin
            if (bclk_rise)
                word <= {word[WORD_W-2:0], bit_in};
            if (ws_edge)
                cnt <= bclk_rise ? CNT_W'(1) : '0;
            else if (bclk_rise && cnt != CNT_SAT)
                cnt <= cnt + 1'b1;
        end
    end

    assign slot_full = (cnt == CNT_SAT);
endmodule

// File: rtl/rj_audio_rx.sv
module rj_audio_rx
    import rjrx_pkg::*;
#(
    parameter int unsigned MIN_PERIOD  = RJ_MIN_PERIOD,
    parameter int unsigned SYNC_STAGES = RJ_SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_in,
    input  logic                 ws_in,
    input  logic                 sd_in,
    output logic [RJ_WORD_W-1:0] smp_data,
    output logic                 smp_left,
    output logic                 smp_valid,
    output logic                 frame_err
);
    localparam int unsigned MIN_SLOT = MIN_PERIOD / 2;

    logic [2:0]           pins_s;
    logic                 bclk_rise;
    logic                 ws_edge;
    logic                 ws_level_old;
    logic [RJ_WORD_W-1:0] shift_word;
    logic                 slot_full;
    logic                 armed;
    slot_verdict_e        verdict;
    rj_sample_t           sample_q;

    rjrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({sd_in, ws_in, bclk_in}),
        .d_sync  (pins_s)
    );

    rjrx_edge u_edge (
        .clk          (clk),
        .rst          (rst),
        .bclk_s       (pins_s[0]),
        .ws_s         (pins_s[1]),
        .bclk_rise    (bclk_rise),
        .ws_edge      (ws_edge),
        .ws_level_old (ws_level_old)
    );

    rjrx_shift #(.WORD_W(RJ_WORD_W), .MIN_SLOT(MIN_SLOT)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (pins_s[2]),
        .bclk_rise (bclk_rise),
        .ws_edge   (ws_edge),
        .word      (shift_word),
        .slot_full (slot_full)
    );

    always_comb verdict = judge_slot(ws_edge, armed, slot_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            sample_q  <= '0;
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            frame_err <= 1'b0;
            unique case (verdict)
                SLOT_PRIME:  armed <= 1'b1;
                SLOT_ACCEPT: begin
                    sample_q.word <= shift_word;
                    sample_q.left <= ws_level_old;
                    smp_valid     <= 1'b1;
                end
                SLOT_SHORT:  frame_err <= 1'b1;
                default:     ;
            endcase
        end
    end

    assign smp_data = sample_q.word;
    assign smp_left = sample_q.left;
endmodule

// File: rtl/rjrx_checker.sv
module rjrx_checker
    import rjrx_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [RJ_WORD_W-1:0] smp_data,
    input logic                 smp_left,
    input logic                 smp_valid,
    input logic                 frame_err,
    input logic                 ws_edge
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!smp_valid && !frame_err && smp_data == '0 && !smp_left));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    assert_strobe_needs_edge_R4: assert property (@(posedge clk) disable iff (rst)
        (smp_valid || frame_err) |-> $past(ws_edge));

    assert_err_excludes_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !(smp_valid && frame_err));

    assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(smp_data) && $stable(smp_left)));
endmodule

bind rj_audio_rx rjrx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_data  (smp_data),
    .smp_left  (smp_left),
    .smp_valid (smp_valid),
    .frame_err (frame_err),
    .ws_edge   (ws_edge)
);

// File: tb/rj_audio_rx_tb.sv
module rj_audio_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_in = 1'b0;
    logic        ws_in = 1'b0;
    logic        sd_in = 1'b0;
    logic [17:0] smp_data;
    logic        smp_left;
    logic        smp_valid;
    logic        frame_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    string scen = "R1";

    // behavioural reference model
    logic [17:0] m_sr = '0;
    int          m_cnt = 0;
    bit          m_armed = 1'b0;
    bit          m_ws = 1'b0;
    int          exp_kind [int];   // 1 = sample, 2 = short-slot error
    logic [17:0] exp_word [int];
    bit          exp_left [int];
    logic [17:0] h_data = '0;
    bit          h_left = 1'b0;

    rj_audio_rx u_dut (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .ws_in(ws_in), .sd_in(sd_in),
        .smp_data(smp_data), .smp_left(smp_left), .smp_valid(smp_valid),
        .frame_err(frame_err)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (scenario %s) cycle %0d: actual=%0h expected=%0h",
                     req, scen, cyc, act, exp);
        end
    endtask

    // comparison on every clock against the schedule
    always @(negedge clk) begin
        if (rst) begin
            check("R1 valid", 32'(smp_valid), 0);
            check("R1 err",   32'(frame_err), 0);
            check("R1 data",  32'(smp_data),  0);
        end else if (!done) begin
            int k;
            k = exp_kind.exists(cyc) ? exp_kind[cyc] : 0;
            if (k == 1) begin
                h_data = exp_word[cyc];
                h_left = exp_left[cyc];
            end
            check("R4 valid",    32'(smp_valid), 32'(k == 1));
            check("R6 err",      32'(frame_err), 32'(k == 2));
            check("R2/R8 data",  32'(smp_data),  32'(h_data));
            check("R3/R8 left",  32'(smp_left),  32'(h_left));
        end
    end

    task automatic ws_event(input bit lvl);
        if (!m_armed) begin
            m_armed = 1'b1;                       // R7: first change primes only
        end else if (m_cnt >= 18) begin
            exp_kind[cyc + 3] = 1;
            exp_word[cyc + 3] = m_sr;
            exp_left[cyc + 3] = m_ws;
        end else begin
            exp_kind[cyc + 3] = 2;                // R6
        end
        m_cnt = 0;
        m_ws  = lvl;
    endtask

    task automatic drive_bit(input bit lvl, input logic b);
        @(negedge clk);
        bclk_in = 1'b0;
        sd_in   = b;
        if (lvl != m_ws) begin
            ws_event(lvl);
            ws_in = lvl;
        end
        repeat (3) @(negedge clk);
        @(negedge clk);
        bclk_in = 1'b1;
        m_sr  = {m_sr[16:0], b};
        m_cnt = m_cnt + 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic slot(input bit lvl, input int n, input logic [17:0] w, input logic filler);
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = n - 1 - i;
            drive_bit(lvl, (idx < 18) ? w[idx] : filler);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        scen = "R7";  slot(1'b1, 18, 18'h2A5C3, 1'b0);
        scen = "R2";  slot(1'b0, 18, 18'h1F00F, 1'b0);
        scen = "R3";  slot(1'b1, 18, 18'h00001, 1'b0);
        scen = "R5";  slot(1'b0, 23, 18'h15555, 1'b1);
        scen = "R5";  slot(1'b1, 30, 18'h3FFFE, 1'b0);
        scen = "R6";  slot(1'b0, 10, 18'h0ABCD, 1'b1);
        scen = "R6";  slot(1'b1, 17, 18'h12345, 1'b0);
        scen = "R2";  slot(1'b0, 18, 18'h20000, 1'b0);
        scen = "R2";  slot(1'b1, 18, 18'h3FFFF, 1'b0);
        scen = "R8";  slot(1'b0, 1, 18'h00001, 1'b0);
        scen = "R4";  slot(1'b1, 19, 18'h0C0C3, 1'b1);
        scen = "R4";  slot(1'b0, 1, 18'h00000, 1'b0);
        repeat (12) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule